// File: doc/BRIEF.md
# Reference-Window Clock Frequency Meter

This block measures the frequency of one clock chosen from two banks of on-chip clock sources. The measurement uses the block's own bus clock, a fixed reference, as the time base. Software selects a source by writing a 6-bit index into the selection register. An auxiliary register picks the second bank, and sources in that bank pass through a divide-by-two stage before they reach the counter. A single write to the control register then arms the meter and starts it. The control register has an enable bit and a shared start/busy bit.

While a measurement runs, the block opens a gate for exactly one window of reference cycles (1024 by default). The gate passes through a two-flop synchroniser into the measured clock's domain, where a saturating counter counts edges. When the gate closes, the counter's domain returns a level acknowledge. The reference side waits for that acknowledge to fall before it copies the now-frozen count into the result register and drops busy. Software converts the count to kHz as count × reference kHz / window. For the second bank it doubles that figure.

A source that is gated off, or source index 0, never returns an acknowledge. The meter still closes its window, reports a count of zero and clears busy.

Top module: `freq_meter`

## Requirements
- R1: After reset, all four registers read zero: selection (address 0), auxiliary (address 1), control (address 2) and result (address 3).
- R2: The selection register keeps a first-bank index in bits 13:8, a second-bank index in bits 21:16 and a 2-bit mode in bits 1:0. All other bits read 0, so writing all ones reads back 0x003F3F03.
- R3: Auxiliary bit 24 chooses the second bank and its divide-by-two stage. All other auxiliary bits read 0, so writing all ones reads back 0x01000000.
- R4: Control bit 12 is the enable and reads back as written. A control write with bits 12 and 4 both 1 starts a measurement, and bit 4 reads 1 on the very next bus read. A write of 0x1000 alone leaves bit 4 at 0.
- R5: The gate stays open for exactly WINDOW reference cycles. Busy clears a short synchroniser delay later, between WINDOW+1 and WINDOW+56 cycles after the start write.
- R6: For a first-bank source, result bits 15:0 hold the number of source edges within the window: about WINDOW × Tref / Tsrc, within ±3.
- R7: For a second-bank source, the result is half the edge count of the source itself: about WINDOW × Tref / (2 × Tsrc), within ±3.
- R8: The edge counter saturates at all ones (2^CNT_W − 1) and never wraps.
- R9: A gated-off source, or index 0, leaves the result at 0, and busy still clears within the R5 bound.
- R10: A control write with bit 12 at 0 stops a running measurement. Busy and enable both read 0 on the next read, and the result keeps its previous value.
- R11: A start write that arrives while a measurement is running is ignored. The window is not restarted, and busy clears within the R5 bound measured from the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference and bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| srcA | input | NUM_SRC | First-bank source clocks, bit 0 unused |
| srcB | input | NUM_SRC | Second-bank source clocks, bit 0 unused |

## Verification
The collision of interest is a fresh start write landing in a cycle in which the reference window counter is advancing mid-window. The bench issues a second start around 500 cycles into a running window. It then checks that busy still clears within the bound counted from the first start, and that the count still matches a single full window. The bench also provokes an abort while the measured domain is still counting. It judges that abort at the ports: busy and enable must read 0 on the next read, and the result must read the same before and after.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int ID_W    = 6;
  localparam int NUM_SRC = 1 << ID_W;

  localparam logic [1:0] ADDR_SEL = 2'd0;
  localparam logic [1:0] ADDR_AUX = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_RES = 2'd3;

  localparam int ENA_BIT  = 12;
  localparam int GO_BIT   = 4;
  localparam int BANKB_BIT = 24;
  localparam int IDA_LSB  = 8;
  localparam int IDB_LSB  = 16;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SETTLE, ST_WINDOW, ST_DRAIN
  } fmState_t;

  typedef struct packed {
    logic gateOn;
    logic capture;
    logic zeroResult;
  } fmStrobe_t;
endpackage

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int WINDOW = 1024,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             ackSync,
  input  logic [CNT_W-1:0] resultIn,
  output logic [31:0]      rdata,
  output fmStrobe_t        strobe,
  output logic [ID_W-1:0]  idA,
  output logic [ID_W-1:0]  idB,
  output logic             useB
);
  localparam int REF_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(WINDOW - 1);

  fmState_t         state;
  logic [REF_W-1:0] refCnt;
  logic             ackSeen;
  logic             enable;
  logic [1:0]       mode;
  logic             busy;
  logic             unusedWdata;

  wire ctlWr    = wrEn && (addr == ADDR_CTL);
  wire startReq = ctlWr && wdata[ENA_BIT] && wdata[GO_BIT];
  wire abortReq = ctlWr && !wdata[ENA_BIT];

  assign unusedWdata = ^{wdata[31:25], wdata[23:22], wdata[15:14], wdata[11:5], wdata[3:2]};
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      refCnt  <= '0;
      ackSeen <= 1'b0;
      enable  <= 1'b0;
      mode    <= '0;
      idA     <= '0;
      idB     <= '0;
      useB    <= 1'b0;
    end else begin
      if (wrEn && addr == ADDR_SEL) begin
        idA  <= wdata[IDA_LSB +: ID_W];
        idB  <= wdata[IDB_LSB +: ID_W];
        mode <= wdata[1:0];
      end
      if (wrEn && addr == ADDR_AUX) useB <= wdata[BANKB_BIT];
      if (ctlWr) enable <= wdata[ENA_BIT];
      if (abortReq) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE:   if (startReq) state <= ST_SETTLE;
          ST_SETTLE: if (!ackSync) begin
            state   <= ST_WINDOW;
            refCnt  <= '0;
            ackSeen <= 1'b0;
          end
          ST_WINDOW: begin
            if (ackSync) ackSeen <= 1'b1;
            if (refCnt == REF_LAST) state <= ST_DRAIN;
            else refCnt <= refCnt + 1'b1;
          end
          default: begin
            if (ackSync) ackSeen <= 1'b1;
            else state <= ST_IDLE;
          end
        endcase
      end
    end
  end

  always_comb begin
    strobe.gateOn     = (state == ST_WINDOW);
    strobe.capture    = (state == ST_DRAIN) && !ackSync && !abortReq;
    strobe.zeroResult = !ackSeen;
  end

  always_comb begin
    case (addr)
      ADDR_SEL: rdata = {10'b0, idB, 2'b0, idA, 6'b0, mode};
      ADDR_AUX: rdata = {7'b0, useB, 24'b0};
      ADDR_CTL: rdata = {19'b0, enable, 7'b0, busy, 4'b0};
      default:  rdata = 32'(resultIn);
    endcase
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> busy); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!busy && !strobe.gateOn)); // R10
  AST_GATE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.gateOn && !abortReq && refCnt != REF_LAST) |=> strobe.gateOn); // R5
  AST_GATE_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.gateOn && refCnt == REF_LAST) |=> !strobe.gateOn); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && startReq && refCnt != REF_LAST) |=> (refCnt == $past(refCnt) + 1'b1)); // R11
endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
  import fm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcA,
  input  logic [NUM_SRC-1:0] srcB,
  input  logic [ID_W-1:0]    idA,
  input  logic [ID_W-1:0]    idB,
  input  logic               useB,
  input  fmStrobe_t          strobe,
  output logic               ackSync,
  output logic [CNT_W-1:0]   result
);
  logic             rawA, rawB, divB, mClk;
  logic [1:0]       gSync;
  logic             ackT, ackMeta;
  logic [CNT_W-1:0] tgtCnt;

  assign rawA = (idA == '0) ? 1'b0 : srcA[idA];
  assign rawB = (idB == '0) ? 1'b0 : srcB[idB];

  always_ff @(posedge rawB or negedge rstN) begin
    if (!rstN) divB <= 1'b0;
    else       divB <= ~divB;
  end

  assign mClk = useB ? divB : rawA;

  wire firstEdge = gSync[1] && !ackT;

  always_ff @(posedge mClk or negedge rstN) begin
    if (!rstN) begin
      gSync  <= '0;
      ackT   <= 1'b0;
      tgtCnt <= '0;
    end else begin
      gSync <= {gSync[0], strobe.gateOn};
      ackT  <= gSync[1];
      if (firstEdge)                      tgtCnt <= '0;
      else if (gSync[1] && tgtCnt != '1) tgtCnt <= tgtCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackMeta <= 1'b0;
      ackSync <= 1'b0;
      result  <= '0;
    end else begin
      ackMeta <= ackT;
      ackSync <= ackMeta;
      if (strobe.capture) result <= strobe.zeroResult ? '0 : tgtCnt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge mClk) disable iff (!rstN)
    (tgtCnt == '1 && !firstEdge) |=> (tgtCnt == '1)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(result)); // R10
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int WINDOW = 1024,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_SRC-1:0] srcA,
  input  logic [NUM_SRC-1:0] srcB
);
  fmStrobe_t        strobe;
  logic             ackSync;
  logic [CNT_W-1:0] result;
  logic [ID_W-1:0]  idA, idB;
  logic             useB;

  fm_ctrl #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .ackSync(ackSync), .resultIn(result), .rdata(rdata), .strobe(strobe),
    .idA(idA), .idB(idB), .useB(useB)
  );

  fm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB), .idA(idA), .idB(idB),
    .useB(useB), .strobe(strobe), .ackSync(ackSync), .result(result)
  );
endmodule

// File: tb/freq_meter_bench.sv
`timescale 1ns/1ps
module freq_meter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata, rdataSat;
  logic [63:0] srcA, srcB;
  logic        clk10 = 1'b0, clk7 = 1'b0, clk5 = 1'b0;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct { int expV; int tol; string tag; } item_t;
  item_t q[$];
  event  resultReady;

  always #2 clk = ~clk;
  always #5 clk10 = ~clk10;
  always #3.5 clk7 = ~clk7;
  always #2.5 clk5 = ~clk5;

  assign srcA = (64'(clk10) << 5) | (64'(clk7) << 17);
  assign srcB = (64'(clk5) << 33);

  freq_meter u_freq_meter (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .srcA(srcA), .srcB(srcB));
  freq_meter #(.CNT_W(8)) u_freq_meterSat (.clk(clk), .rstN(rstN), .wrEn(wrEn),
    .addr(addr), .wdata(wdata), .rdata(rdataSat), .srcA(srcA), .srcB(srcB));

  task automatic chk(string tag, int act, int expV, int tol);
    checks++;
    if (act < expV - tol || act > expV + tol) begin
      errs++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h) tol=%0d",
               tag, act, act, expV, expV, tol);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic waitIdle(bit restart, output int cycles);
    logic [31:0] d;
    cycles = 0;
    do begin
      @(negedge clk); cycles++;
      if (restart && cycles == 500) begin
        busWrite(2'd2, 32'h1010); cycles += 2;   // R11 second start mid-window
      end
      busRead(2'd2, d);
    end while (d[4] && cycles < 3000);
  endtask

  task automatic measure(bit bankB, int id, int expV, int tol, string tag, bit restart);
    logic [31:0] d;
    int cycles;
    busWrite(2'd0, bankB ? (32'(id) << 16) : ((32'(id) << 8) | 32'h1));
    busWrite(2'd1, bankB ? 32'h0100_0000 : 32'h0);
    busWrite(2'd2, 32'h1000);
    busRead(2'd2, d);
    chk("R4 enable-only keeps idle", int'(d), 32'h1000, 0);
    busWrite(2'd2, 32'h1010);
    busRead(2'd2, d);
    chk("R4 busy on first read", int'(d[4]), 1, 0);
    q.push_back('{expV, tol, tag});
    waitIdle(restart, cycles);
    chk(restart ? "R11 busy bound after restart" : "R5 busy duration", cycles, 1050, 25);
    ->resultReady;
    wait (q.size() == 0);
  endtask

  initial begin : monitor
    item_t it;
    logic [31:0] d;
    forever begin
      @(resultReady);
      it = q.pop_front();
      busRead(2'd3, d);
      chk(it.tag, int'(d), it.expV, it.tol);
    end
  end

  initial begin : driver
    logic [31:0] d, prevRes;
    int cycles;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a), d);
      chk("R1 reset value", int'(d), 0, 0);
    end
    busWrite(2'd0, 32'hFFFF_FFFF);
    busRead(2'd0, d);
    chk("R2 selection fields", int'(d), 32'h003F_3F03, 0);
    busWrite(2'd1, 32'hFFFF_FFFF);
    busRead(2'd1, d);
    chk("R3 bank select bit", int'(d), 32'h0100_0000, 0);
    busWrite(2'd1, 32'h0);

    measure(1'b0, 5, 410, 3, "R6 bank A 10ns", 1'b0);
    repeat (30) @(negedge clk);
    addr = 2'd3; #1;
    chk("R8 saturated count", int'(rdataSat), 255, 0);
    measure(1'b0, 17, 585, 3, "R6 bank A 7ns", 1'b0);
    measure(1'b1, 33, 410, 3, "R7 bank B 5ns halved", 1'b0);

    busRead(2'd3, prevRes);
    busWrite(2'd0, 32'(17) << 8);
    busWrite(2'd1, 32'h0);
    busWrite(2'd2, 32'h1010);
    repeat (100) @(negedge clk);
    busWrite(2'd2, 32'h0);
    busRead(2'd2, d);
    chk("R10 abort clears busy and enable", int'(d), 0, 0);
    busRead(2'd3, d);
    chk("R10 result kept after abort", int'(d), int'(prevRes), 0);
    repeat (50) @(negedge clk);
    busRead(2'd3, d);
    chk("R10 result still kept", int'(d), int'(prevRes), 0);

    measure(1'b0, 17, 585, 3, "R11 count after ignored restart", 1'b1);
    measure(1'b0, 9, 0, 0, "R9 gated-off source", 1'b0);
    measure(1'b0, 5, 410, 3, "R6 bank A repeat", 1'b0);
    measure(1'b0, 0, 0, 0, "R9 index zero", 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule